// File: doc/BRIEF.md
# Serial Audio Transmit Controller

This block takes audio samples from a host over a small word-addressed register interface and sends them out as a standard I2S serial stream. Samples written to the data slot queue in a 32-entry FIFO. The system clock acts as the master clock. A programmable divider turns it into a bit clock. A second divider, counted in bit clocks, sets the frame length and produces the left/right word clock. Each FIFO word holds one right-justified sample, and consecutive words take turns between the left slot (word clock low) and the right slot (word clock high).

Software writes the sample width and the two divider values, can preload the FIFO while the transmitter is off, and then sets the transmit enable bit. After that it tops up the FIFO whenever the level register shows free space. When the FIFO runs dry during a slot, silence goes out and a sticky underrun flag is raised. A write to the clear slot flushes the queue, resets the serializer and drops that flag. Slots reserved for receive, DMA and interrupt functions read as zero.

Top module: `i2s_tx_top`

## Requirements
- R1: After reset, the register values read back as follows: width register (byte offset 0x00) = 15 (16-bit samples), divider register (0x08) = 0x0007001F, level register (0x0C) = 0, enable register (0x1C) = 0.
- R2: The byte offsets 0x04, 0x10, 0x14, 0x18, 0x24 and 0x28 read as zero. The data slot at 0x24 is write-only.
- R3: The width register holds bits [4:0] (sample width minus one). The divider register holds bits [23:16] (master clocks per bit minus one) and bits [7:0] (bit clocks per frame minus one). Bits [15:8] are reserved and read zero.
- R4: With enable bit 0 (offset 0x1C) clear, the bit clock stays low, the data line stays low and the word clock stays high, while writes to the data slot are still queued. Bit 1 of that register is stored and read back, and has no effect on the output.
- R5: Level register bits [5:0] give the number of queued words, 0 to 32. A data write while 32 words are queued is dropped, and the level changes by at most one per cycle.
- R6: While enabled, one bit clock period lasts (divider[23:16]+1) master clocks. The bit clock is high in its second half and falls at the end of each period.
- R7: One frame lasts (divider[7:0]+1) bit clocks. The word clock is low for the first half of the frame and high for the second half, and it changes only as the bit clock falls.
- R8: Each sample goes out MSB first, with its MSB in the second bit of its slot (one bit clock after the word clock changes). It is (width+1) bits long and taken from the low bits of the word. Unused bits are zero. The data line changes only as the bit clock falls.
- R9: If the FIFO is empty when a slot begins, that slot carries zeros and level register bit 8 is set. The bit stays set until a clear.
- R10: Any write to offset 0x20 empties the FIFO, clears the underrun bit and returns the serializer to idle with the data line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used as the master audio clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe for one cycle |
| busAddr | input | 6 | Byte address of the register slot |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| sclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right word clock |
| sdo | output | 1 | Serial data |

## Verification
A register write takes effect at the next rising edge, and reads are combinational, so the bench drives the bus on the falling edge and samples the read data 1 ns after setting the address. Serial data and the word clock move in the same master-clock edge that drops the bit clock. The bench therefore samples each bit 1 ns after a rising bit-clock edge, mid-bit. It discards the first rising edge after enable, because that edge comes before the first slot begins. The underrun bit becomes visible at the start of the first slot with no data. The bench reads it only after that slot has been fully captured.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  localparam int WORD_W = 32;
  localparam int WID_W  = 5;
  localparam int DIV_W  = 8;

  typedef struct packed {
    logic              pushStb;
    logic              clearStb;
    logic              txEn;
    logic [WID_W-1:0]  widthM1;
    logic [DIV_W-1:0]  mDivM1;
    logic [DIV_W-1:0]  fDivM1;
    logic [WORD_W-1:0] pushData;
  } ctl_t;
endpackage

// File: rtl/i2s_tx_fifo.sv
`timescale 1ns/1ps
module i2s_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wData,
  input  logic             pop,
  output logic [W-1:0]     rData,
  output logic [LVL_W-1:0] level,
  output logic             empty
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic            doPush, doPop;

  assign empty  = (level == '0);
  assign doPush = push && (level != LVL_W'(DEPTH));
  assign doPop  = pop && !empty;
  assign rData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2s_tx_ctrl.sv
`timescale 1ns/1ps
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic [LVL_W-1:0]  level,
  input  logic              underrun,
  output ctl_t              ctlBus
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] SLOT_WIDTH = IDX_W'(0);
  localparam logic [IDX_W-1:0] SLOT_DIV   = IDX_W'(2);
  localparam logic [IDX_W-1:0] SLOT_LVL   = IDX_W'(3);
  localparam logic [IDX_W-1:0] SLOT_XFER  = IDX_W'(7);
  localparam logic [IDX_W-1:0] SLOT_CLR   = IDX_W'(8);
  localparam logic [IDX_W-1:0] SLOT_DATA  = IDX_W'(9);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic [WID_W-1:0] widthM1;
  logic [DIV_W-1:0] mDivM1, fDivM1;
  logic [1:0]       xferBits;

  assign idx     = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthM1  <= WID_W'(15);
      mDivM1   <= DIV_W'(7);
      fDivM1   <= DIV_W'(31);
      xferBits <= 2'b00;
    end else if (busWrEn && aligned) begin
      case (idx)
        SLOT_WIDTH: widthM1 <= busWrData[WID_W-1:0];
        SLOT_DIV: begin
          mDivM1 <= busWrData[16 +: DIV_W];
          fDivM1 <= busWrData[0 +: DIV_W];
        end
        SLOT_XFER: xferBits <= busWrData[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdData = '0;
    if (aligned) begin
      case (idx)
        SLOT_WIDTH: busRdData[WID_W-1:0] = widthM1;
        SLOT_DIV: begin
          busRdData[16 +: DIV_W] = mDivM1;
          busRdData[0 +: DIV_W]  = fDivM1;
        end
        SLOT_LVL: begin
          busRdData[LVL_W-1:0] = level;
          busRdData[8]         = underrun;
        end
        SLOT_XFER: busRdData[1:0] = xferBits;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctlBus          = '0;
    ctlBus.pushStb  = busWrEn && aligned && (idx == SLOT_DATA);
    ctlBus.clearStb = busWrEn && aligned && (idx == SLOT_CLR);
    ctlBus.txEn     = xferBits[0];
    ctlBus.widthM1  = widthM1;
    ctlBus.mDivM1   = mDivM1;
    ctlBus.fDivM1   = fDivM1;
    ctlBus.pushData = busWrData;
  end
endmodule

// File: rtl/i2s_tx_datapath.sv
`timescale 1ns/1ps
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctlBus,
  output logic [LVL_W-1:0] level,
  output logic             underrun,
  output logic             sclk,
  output logic             lrclk,
  output logic             sdo
);
  logic [WORD_W-1:0] rData, aligned, shReg;
  logic              empty, tick, slotStart, pop;
  logic [DIV_W-1:0]  mCnt, bitCnt, nextBit;
  logic [DIV_W:0]    halfM, halfF;

  i2s_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .clr(ctlBus.clearStb),
    .push(ctlBus.pushStb), .wData(ctlBus.pushData),
    .pop(pop), .rData(rData), .level(level), .empty(empty)
  );

  assign halfM     = ({1'b0, ctlBus.mDivM1} + 1'b1) >> 1;
  assign halfF     = ({1'b0, ctlBus.fDivM1} + 1'b1) >> 1;
  assign tick      = ctlBus.txEn && (mCnt == ctlBus.mDivM1);
  assign nextBit   = (bitCnt == ctlBus.fDivM1) ? '0 : bitCnt + 1'b1;
  assign slotStart = (nextBit == '0) || ({1'b0, nextBit} == halfF);
  assign pop       = tick && slotStart;
  assign aligned   = rData << (WID_W'(WORD_W - 1) - ctlBus.widthM1);
  assign sclk      = ctlBus.txEn && ({1'b0, mCnt} >= halfM);
  assign lrclk     = ({1'b0, bitCnt} >= halfF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt     <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      sdo      <= 1'b0;
      underrun <= 1'b0;
    end else if (ctlBus.clearStb || !ctlBus.txEn) begin
      mCnt   <= '0;
      bitCnt <= ctlBus.fDivM1;
      shReg  <= '0;
      sdo    <= 1'b0;
      if (ctlBus.clearStb) underrun <= 1'b0;
    end else if (tick) begin
      mCnt   <= '0;
      bitCnt <= nextBit;
      sdo    <= shReg[WORD_W-1];
      if (slotStart) begin
        shReg <= empty ? '0 : aligned;
        if (empty) underrun <= 1'b1;
      end else begin
        shReg <= shReg << 1;
      end
    end else begin
      mCnt <= mCnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_top.sv
`timescale 1ns/1ps
module i2s_tx_top
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 6,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              sclk,
  output logic              lrclk,
  output logic              sdo
);
  ctl_t             ctlBus;
  logic [LVL_W-1:0] lvl;
  logic             underrunFlag;

  i2s_tx_ctrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .level(lvl), .underrun(underrunFlag), .ctlBus(ctlBus)
  );

  i2s_tx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctlBus(ctlBus), .level(lvl),
    .underrun(underrunFlag), .sclk(sclk), .lrclk(lrclk), .sdo(sdo)
  );
endmodule

// File: rtl/i2s_tx_chk.sv
`timescale 1ns/1ps
module i2s_tx_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclk,
  input logic             lrclk,
  input logic             sdo,
  input logic [LVL_W-1:0] level,
  input logic             underrun,
  input logic             clearStb,
  input logic             txEn
);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH);

  // R5
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clearStb) |-> (int'(level) - int'($past(level)) <= 1) &&
                         (int'($past(level)) - int'(level) <= 1));

  // R8
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdo) && $past(txEn) && !$past(clearStb)) |-> $fell(sclk));

  // R7
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(lrclk) && $past(txEn) && txEn && !$past(clearStb)) |-> $fell(sclk));

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(underrun) && !$past(clearStb)) |-> underrun);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearStb) |-> (level == '0) && !underrun && !sdo);
endmodule

bind i2s_tx_top i2s_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .lrclk(lrclk), .sdo(sdo),
  .level(lvl), .underrun(underrunFlag),
  .clearStb(ctlBus.clearStb), .txEn(ctlBus.txEn)
);

// File: tb/i2s_tx_top_bench.sv
`timescale 1ns/1ps
module i2s_tx_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        sclk, lrclk, sdo;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [31:0] txWords [0:7];
  logic        capBit  [0:127];
  logic        capLr   [0:127];
  realtime     tRise1, tRise2;

  always #2.5 clk = ~clk;

  i2s_tx_top u_i2s_tx_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .sclk(sclk), .lrclk(lrclk), .sdo(sdo)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic expectReg(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    busRead(a, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic testReset();
    expectReg(6'h00, 32'h0000_000F, "R1 width reset");
    expectReg(6'h08, 32'h0007_001F, "R1 divider reset");
    expectReg(6'h0C, 32'h0, "R1 level reset");
    expectReg(6'h1C, 32'h0, "R1 enable reset");
    expectReg(6'h04, 32'h0, "R2 rx ctl slot");
    expectReg(6'h10, 32'h0, "R2 dma slot");
    expectReg(6'h14, 32'h0, "R2 int ctl slot");
    expectReg(6'h18, 32'h0, "R2 int status slot");
    expectReg(6'h24, 32'h0, "R2 data slot read");
    expectReg(6'h28, 32'h0, "R2 rx data slot");
    check({sclk, lrclk, sdo} === 3'b010, "R4 idle pins after reset", {sclk, lrclk, sdo}, 3'b010);
  endtask

  task automatic testConfig();
    busWrite(6'h00, 32'hFFFF_FFF7);
    expectReg(6'h00, 32'h0000_0017, "R3 width field");
    busWrite(6'h08, 32'hABFF_CD12);
    expectReg(6'h08, 32'h00FF_0012, "R3 divider fields");
    busWrite(6'h00, 32'hF);
    busWrite(6'h08, 32'h0007_001F);
  endtask

  task automatic testFill();
    bit quiet = 1'b1;
    busWrite(6'h1C, 32'h2);
    expectReg(6'h1C, 32'h2, "R4 rx enable bit readback");
    for (int i = 0; i < 32; i++) begin
      busWrite(6'h24, 32'h100 + i);
      if (sclk !== 1'b0 || sdo !== 1'b0 || lrclk !== 1'b1) quiet = 1'b0;
    end
    check(quiet, "R4 no serial activity while disabled", quiet, 1);
    expectReg(6'h0C, 32'd32, "R5 level after 32 writes");
    busWrite(6'h24, 32'hDEAD);
    expectReg(6'h0C, 32'd32, "R5 write when full dropped");
    busWrite(6'h1C, 32'h0);
    busWrite(6'h20, 32'h0);
    expectReg(6'h0C, 32'd0, "R10 clear empties FIFO");
  endtask

  task automatic runStream(input int nWords, input int wM1, input int mDiv,
                           input int fDiv, input int nBits, input string tag);
    int slot, errD, errL, w;
    logic expB [0:127];
    busWrite(6'h20, 32'h0);
    busWrite(6'h00, wM1);
    busWrite(6'h08, (mDiv << 16) | fDiv);
    for (int i = 0; i < nWords; i++) busWrite(6'h24, txWords[i]);
    busWrite(6'h1C, 32'h1);
    @(posedge sclk);
    for (int n = 0; n < nBits; n++) begin
      @(posedge sclk);
      if (n == 1) tRise1 = $realtime;
      if (n == 2) tRise2 = $realtime;
      #1;
      capBit[n] = sdo;
      capLr[n]  = lrclk;
    end
    slot = (fDiv + 1) / 2;
    w = wM1 + 1;
    for (int n = 0; n < 128; n++) expB[n] = 1'b0;
    for (int s = 0; s < nWords; s++)
      for (int i = 0; i < w; i++)
        if (s * slot + 1 + i < nBits) expB[s * slot + 1 + i] = txWords[s][w - 1 - i];
    errD = 0; errL = 0;
    for (int n = 0; n < nBits; n++) begin
      if (capBit[n] !== expB[n]) errD++;
      if (capLr[n] !== ((n % (fDiv + 1)) >= slot)) errL++;
    end
    check(errD == 0, {tag, " R8 serial data bits"}, errD, 0);
    check(errL == 0, {tag, " R7 word clock pattern"}, errL, 0);
    check(tRise2 - tRise1 == 5.0 * (mDiv + 1), {tag, " R6 bit clock period"},
          longint'(tRise2 - tRise1), longint'(5.0 * (mDiv + 1)));
  endtask

  task automatic testStream16();
    txWords[0] = 32'hFFFF_A5C3; txWords[1] = 32'h0000_1234;
    txWords[2] = 32'h0000_8001; txWords[3] = 32'h5555_7FFE;
    runStream(4, 15, 3, 31, 80, "w16");
    expectReg(6'h0C, 32'h0000_0100, "R9 underrun flag after drain");
    busWrite(6'h1C, 32'h0);
    expectReg(6'h0C, 32'h0000_0100, "R9 flag sticky when disabled");
    busWrite(6'h20, 32'h0);
    expectReg(6'h0C, 32'h0, "R10 clear drops underrun");
    check(sdo === 1'b0, "R10 data line low after clear", sdo, 0);
  endtask

  task automatic testStream24();
    txWords[0] = 32'hFFAB_CDEF; txWords[1] = 32'h0012_3456;
    runStream(2, 23, 1, 63, 64, "w24");
    busWrite(6'h1C, 32'h0);
    busWrite(6'h20, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testConfig();
    testFill();
    testStream16();
    testStream24();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule